// File: doc/BRIEF.md
# Envelope Tracking Reference Generator

This block turns multichannel audio into a slowly varying, always-positive reference sample for a power-supply control converter, so that the supply rails of a linear amplifier follow the programme level. Deframed samples from two time-division streams arrive one slot per cycle, each tagged with its stream and slot number. A per-channel exclusion mask chooses which channels count. Across the frame, the block keeps the largest absolute value among the counted slots. When the frame-end strobe arrives, that frame peak is compared with a held envelope value. A larger peak replaces the held value at once. A smaller one replaces it only after a programmable number of frames has passed, which should be set to match the audio path's group delay.

The held envelope is scaled by an unsigned fixed-point gain to match the amplifier gain to the supply gain. A DC offset is then added to give headroom, and the result saturates at the largest positive code. One reference sample per frame is produced, marked by a one-cycle valid pulse. The mode field must hold the tracking code for this to happen. In any other mode the output carries only the offset, and the invert control is honoured.

Top module: `env_track_gen`

## Requirements
- R1: While reset is asserted, and until the first frame result, refOut is 0 and refValid is 0.
- R2: A slot counts toward the frame peak only when slotValid is 1 and bit (slotStream*16 + slotIdx) of chanMask is 0. A mask bit of 1 excludes that channel.
- R3: Slot samples are two's-complement and are compared by absolute value. The code -32768 counts as magnitude 32767.
- R4: At a frame end, a frame peak strictly greater than the held envelope is loaded into it at once, and the hold counter restarts at holdFrames.
- R5: If the held envelope is not exceeded, it is kept for exactly holdFrames further frame ends. At the next frame end it takes that frame's peak, even if smaller, and the counter restarts. With holdFrames = 0 the envelope equals each frame's peak.
- R6: With pathMode = 2'b10 (tracking), refOut = min(32767, floor(held * gainQ / 16384) + offset). gainQ is unsigned Q2.14. invertEn is ignored and refOut is never negative.
- R7: The gain-plus-offset result saturates to 32767 and never wraps. In tracking mode, refOut is never below offset.
- R8: refValid is a one-cycle pulse two clock edges after the edge that samples frameEnd. refOut keeps its value between pulses.
- R9: With pathMode other than 2'b10, refOut = offset, or -offset when invertEn = 1.
- R10: A slot presented in the same cycle as frameEnd counts toward the frame being closed. The next frame starts from peak 0, and a frame with no counted slot has peak 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| slotValid | input | 1 | Slot sample present this cycle |
| slotStream | input | 1 | Input stream of the slot (0 or 1) |
| slotIdx | input | 4 | Slot number within its stream |
| slotData | input | 16 | Two's-complement slot sample |
| frameEnd | input | 1 | Closes the current frame |
| chanMask | input | 32 | Exclusion bit per channel, index stream*16+slot |
| pathMode | input | 2 | Path source select; 2'b10 is tracking |
| invertEn | input | 1 | Negate output (non-tracking modes only) |
| gainQ | input | 16 | Unsigned Q2.14 envelope gain |
| offset | input | 15 | DC headroom added after gain |
| holdFrames | input | 8 | Hold window in frames |
| refOut | output | 16 | Reference sample |
| refValid | output | 1 | One-cycle pulse per frame result |

## Verification
Two things can land on the same frame end: the hold counter running out, and the arrival of that frame's peak. The arriving peak may also be the slot presented together with frameEnd. The bench sets up frames in which the counter expires while the frame peak is larger than, equal to or smaller than the held value. It also places the largest sample in the final slot. A reference model predicts which of the two updates should win, and each refOut pulse is compared with it. The expiring-smaller case must drop the envelope, and the larger case must reload it and restart the counter.

// File: rtl/envt_pkg.sv
package envt_pkg;
  typedef struct packed {
    logic frameClose;
    logic loadHeld;
    logic outUpdate;
  } envStrobe_t;

  localparam logic [1:0] MODE_TRACK = 2'b10;
endpackage

// File: rtl/envt_ctrl.sv
module envt_ctrl
  import envt_pkg::*;
#(
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameEnd,
  input  logic              candGt,
  input  logic [HOLD_W-1:0] holdFrames,
  output envStrobe_t        strobe,
  output logic [HOLD_W-1:0] holdCnt
);
  logic outPend;
  logic expired;

  always_comb begin
    expired           = (holdCnt == '0);
    strobe.frameClose = frameEnd;
    strobe.loadHeld   = frameEnd && (candGt || expired);
    strobe.outUpdate  = outPend;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outPend <= 1'b0;
      holdCnt <= '0;
    end else begin
      outPend <= frameEnd;
      if (strobe.loadHeld)
        holdCnt <= holdFrames;
      else if (frameEnd)
        holdCnt <= holdCnt - 1'b1;
    end
  end
endmodule

// File: rtl/envt_dpath.sv
module envt_dpath
  import envt_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int STREAMS   = 2,
  parameter int SLOTS     = 16,
  parameter int GAIN_W    = 16,
  parameter int GAIN_FRAC = 14
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        slotValid,
  input  logic [((STREAMS>1)?$clog2(STREAMS):1)-1:0] slotStream,
  input  logic [$clog2(SLOTS)-1:0]    slotIdx,
  input  logic [DATA_W-1:0]           slotData,
  input  logic [STREAMS*SLOTS-1:0]    chanMask,
  input  logic                        trackOn,
  input  logic                        invertEn,
  input  logic [GAIN_W-1:0]           gainQ,
  input  logic [DATA_W-2:0]           offset,
  input  envStrobe_t                  strobe,
  output logic                        candGt,
  output logic [DATA_W-2:0]           candMag,
  output logic [DATA_W-2:0]           heldMag,
  output logic [DATA_W-1:0]           refOut,
  output logic                        refValid
);
  localparam int STR_W  = (STREAMS > 1) ? $clog2(STREAMS) : 1;
  localparam int MAG_W  = DATA_W - 1;
  localparam int PROD_W = MAG_W + GAIN_W;
  localparam int SCL_W  = PROD_W - GAIN_FRAC;
  localparam int SUM_W  = SCL_W + 1;
  localparam logic [MAG_W-1:0] MAX_MAG = '1;

  logic [STREAMS-1:0] streamHit;
  logic               slotUse;
  logic [MAG_W-1:0]   slotMag;
  logic [MAG_W-1:0]   peakAcc;
  logic [PROD_W-1:0]  prod;
  logic [SCL_W-1:0]   scaled;
  logic [SUM_W-1:0]   sum;
  logic [MAG_W-1:0]   satVal;
  logic [DATA_W-1:0]  offExt;
  logic [DATA_W-1:0]  outNext;

  function automatic logic [MAG_W-1:0] absSat(input logic [DATA_W-1:0] s);
    logic [DATA_W-1:0] neg;
    neg = -s;
    if (!s[DATA_W-1])
      return s[MAG_W-1:0];
    else if (s[MAG_W-1:0] == '0)
      return MAX_MAG;
    else
      return neg[MAG_W-1:0];
  endfunction

  for (genvar s = 0; s < STREAMS; s++) begin : g_stream
    logic [SLOTS-1:0] grpMask;
    assign grpMask      = chanMask[s*SLOTS +: SLOTS];
    assign streamHit[s] = slotValid && (slotStream == STR_W'(s)) && !grpMask[slotIdx];
  end

  always_comb begin
    slotUse = |streamHit;
    slotMag = slotUse ? absSat(slotData) : '0;
    candMag = (slotMag > peakAcc) ? slotMag : peakAcc;
    candGt  = candMag > heldMag;
  end

  always_comb begin
    prod   = PROD_W'(heldMag) * PROD_W'(gainQ);
    scaled = prod[PROD_W-1:GAIN_FRAC];
    sum    = SUM_W'(scaled) + SUM_W'(offset);
    satVal = (sum > SUM_W'(MAX_MAG)) ? MAX_MAG : sum[MAG_W-1:0];
    offExt = {1'b0, offset};
    if (trackOn)
      outNext = {1'b0, satVal};
    else if (invertEn)
      outNext = -offExt;
    else
      outNext = offExt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      peakAcc  <= '0;
      heldMag  <= '0;
      refOut   <= '0;
      refValid <= 1'b0;
    end else begin
      peakAcc  <= strobe.frameClose ? '0 : candMag;
      if (strobe.loadHeld)
        heldMag <= candMag;
      if (strobe.outUpdate)
        refOut <= outNext;
      refValid <= strobe.outUpdate;
    end
  end
endmodule

// File: rtl/env_track_gen.sv
module env_track_gen
  import envt_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int STREAMS   = 2,
  parameter int SLOTS     = 16,
  parameter int GAIN_W    = 16,
  parameter int GAIN_FRAC = 14,
  parameter int HOLD_W    = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     slotValid,
  input  logic                     slotStream,
  input  logic [$clog2(SLOTS)-1:0] slotIdx,
  input  logic [DATA_W-1:0]        slotData,
  input  logic                     frameEnd,
  input  logic [STREAMS*SLOTS-1:0] chanMask,
  input  logic [1:0]               pathMode,
  input  logic                     invertEn,
  input  logic [GAIN_W-1:0]        gainQ,
  input  logic [DATA_W-2:0]        offset,
  input  logic [HOLD_W-1:0]        holdFrames,
  output logic [DATA_W-1:0]        refOut,
  output logic                     refValid
);
  envStrobe_t        strobe;
  logic              candGt;
  logic              trackOn;
  logic [HOLD_W-1:0] holdCnt;
  logic [DATA_W-2:0] candMag;
  logic [DATA_W-2:0] heldMag;

  assign trackOn = (pathMode == MODE_TRACK);

  envt_ctrl #(.HOLD_W(HOLD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .frameEnd(frameEnd), .candGt(candGt),
    .holdFrames(holdFrames), .strobe(strobe), .holdCnt(holdCnt)
  );

  envt_dpath #(
    .DATA_W(DATA_W), .STREAMS(STREAMS), .SLOTS(SLOTS),
    .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .slotValid(slotValid), .slotStream(slotStream),
    .slotIdx(slotIdx), .slotData(slotData), .chanMask(chanMask),
    .trackOn(trackOn), .invertEn(invertEn), .gainQ(gainQ), .offset(offset),
    .strobe(strobe), .candGt(candGt), .candMag(candMag), .heldMag(heldMag),
    .refOut(refOut), .refValid(refValid)
  );
endmodule

// File: rtl/envt_chk.sv
module envt_chk #(
  parameter int DATA_W = 16,
  parameter int HOLD_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              frameEnd,
  input logic              trackOn,
  input logic [DATA_W-2:0] offset,
  input logic [DATA_W-1:0] refOut,
  input logic              refValid,
  input logic              candGt,
  input logic [HOLD_W-1:0] holdCnt,
  input logic [DATA_W-2:0] candMag,
  input logic [DATA_W-2:0] heldMag
);
  // R8
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    refValid |-> $past(frameEnd, 2));

  // R6
  track_nonneg_chk: assert property (@(posedge clk) disable iff (!rstN)
    (refValid && $past(trackOn)) |-> !refOut[DATA_W-1]);

  // R7
  offset_floor_chk: assert property (@(posedge clk) disable iff (!rstN)
    (refValid && $past(trackOn)) |-> (refOut >= {1'b0, $past(offset)}));

  // R4
  peak_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameEnd && candGt) |=> (heldMag == $past(candMag)));

  // R5
  hold_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameEnd && !candGt && holdCnt != '0) |=> (holdCnt == $past(holdCnt) - 1'b1));

  // R5
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameEnd && !candGt && holdCnt != '0) |=> $stable(heldMag));
endmodule

bind env_track_gen envt_chk #(.DATA_W(DATA_W), .HOLD_W(HOLD_W)) u_chk (
  .clk(clk), .rstN(rstN), .frameEnd(frameEnd), .trackOn(trackOn),
  .offset(offset), .refOut(refOut), .refValid(refValid), .candGt(candGt),
  .holdCnt(holdCnt), .candMag(candMag), .heldMag(heldMag)
);

// File: tb/tb_env_track_gen.sv
module tb_env_track_gen;
  logic        clk = 1'b0;
  logic        rstN;
  logic        slotValid, slotStream, frameEnd, invertEn;
  logic [3:0]  slotIdx;
  logic [15:0] slotData, gainQ, refOut;
  logic [31:0] chanMask;
  logic [1:0]  pathMode;
  logic [14:0] offset;
  logic [7:0]  holdFrames;
  logic        refValid;

  always #10 clk = ~clk;

  env_track_gen dut (
    .clk(clk), .rstN(rstN), .slotValid(slotValid), .slotStream(slotStream),
    .slotIdx(slotIdx), .slotData(slotData), .frameEnd(frameEnd),
    .chanMask(chanMask), .pathMode(pathMode), .invertEn(invertEn),
    .gainQ(gainQ), .offset(offset), .holdFrames(holdFrames),
    .refOut(refOut), .refValid(refValid)
  );

  int nChk = 0, nFail = 0;
  int mHeld = 0, mCnt = 0;
  logic [15:0] dat [32];
  logic        vld [32];
  bit done = 0;

  task automatic check(string tag, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int magOf(logic [15:0] s);
    if (s == 16'h8000) return 32767;
    if ($signed(s) < 0) return -$signed(s);
    return int'(s);
  endfunction

  function automatic int expOut();
    int v;
    if (pathMode == 2'b10) begin
      v = ((mHeld * int'(gainQ)) >>> 14) + int'(offset);
      return (v > 32767) ? 32767 : v;
    end
    return invertEn ? -int'(offset) : int'(offset);
  endfunction

  task automatic clearFrame();
    for (int i = 0; i < 32; i++) begin dat[i] = 16'h0; vld[i] = 1'b1; end
  endtask

  task automatic runFrame(string tag);
    int cand = 0;
    for (int i = 0; i < 32; i++)
      if (vld[i] && !chanMask[i] && magOf(dat[i]) > cand) cand = magOf(dat[i]);
    if (cand > mHeld || mCnt == 0) begin mHeld = cand; mCnt = holdFrames; end
    else mCnt--;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      slotValid = vld[i]; slotStream = (i >= 16); slotIdx = 4'(i % 16);
      slotData = dat[i]; frameEnd = (i == 31);
    end
    @(posedge clk);
    @(negedge clk);
    slotValid = 0; frameEnd = 0;
    check({tag, " R8 no early valid"}, int'(refValid), 0);
    @(posedge clk);
    @(negedge clk);
    check({tag, " R8 valid pulse"}, int'(refValid), 1);
    check(tag, $signed(refOut), expOut());
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    rstN = 0; slotValid = 0; slotStream = 0; slotIdx = 0; slotData = 0;
    frameEnd = 0; chanMask = '1; pathMode = 2'b10; invertEn = 0;
    gainQ = 16'd16384; offset = 15'd100; holdFrames = 8'd2;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset out", int'(refOut), 0);
    check("R1 reset valid", int'(refValid), 0);
    rstN = 1;
    @(negedge clk);
    check("R1 after release", int'(refValid), 0);

    // all channels masked: only the offset appears
    clearFrame(); dat[3] = 16'd20000;
    runFrame("R2 all masked");

    // one loud masked channel among unmasked quiet ones
    chanMask = 32'h0000_0020;
    clearFrame(); dat[5] = 16'd30000; dat[9] = 16'd900; dat[17] = 16'hFC18;
    runFrame("R2 masked loud slot");

    // most negative code, saturated sum
    chanMask = '0; clearFrame(); dat[20] = 16'h8000;
    runFrame("R3 R7 most negative");

    // hold then expiry to a smaller peak, offset zero
    offset = 0;
    clearFrame(); dat[1] = 16'd500; runFrame("R5 hold 1");
    clearFrame(); dat[1] = 16'd400; runFrame("R5 hold 2");
    clearFrame(); dat[1] = 16'd300; runFrame("R5 expiry drop");
    // new peak in the slot sharing frameEnd
    clearFrame(); dat[31] = 16'd7000; runFrame("R10 R4 last slot peak");
    clearFrame(); vld[2] = 0; runFrame("R10 R5 empty frame held");
    clearFrame(); runFrame("R5 held second");
    clearFrame(); dat[0] = 16'd7000; runFrame("R5 expiry equal");
    clearFrame(); dat[0] = 16'd6000; runFrame("R5 held third");
    clearFrame(); dat[0] = 16'd6500; runFrame("R5 held fourth");
    clearFrame(); dat[0] = 16'd8000; runFrame("R4 expiry larger");

    // zero hold follows each frame
    holdFrames = 0;
    clearFrame(); dat[7] = 16'd1000; runFrame("R5 zero hold a");
    clearFrame(); dat[7] = 16'd200;  runFrame("R5 zero hold b");

    // gain 2.0 saturation
    gainQ = 16'd32768; offset = 15'd3000;
    clearFrame(); dat[12] = 16'd20000; runFrame("R7 gain saturate");
    gainQ = 16'd8192;
    clearFrame(); dat[12] = 16'd20000; runFrame("R6 half gain");

    // mode and invert
    invertEn = 1;
    clearFrame(); dat[4] = 16'd9000; runFrame("R6 invert ignored");
    pathMode = 2'b00;
    clearFrame(); dat[4] = 16'd9000; runFrame("R9 inverted offset");
    invertEn = 0; pathMode = 2'b01;
    clearFrame(); runFrame("R9 plain offset");

    // constrained random
    for (int f = 0; f < 60; f++) begin
      pathMode   = ($urandom_range(0, 5) == 0) ? 2'($urandom_range(0, 3)) : 2'b10;
      invertEn   = $urandom_range(0, 1);
      holdFrames = 8'($urandom_range(0, 4));
      gainQ      = 16'($urandom_range(0, 65535));
      offset     = 15'($urandom_range(0, 4000));
      chanMask   = $urandom() & $urandom();
      for (int i = 0; i < 32; i++) begin
        dat[i] = ($urandom_range(0, 40) == 0) ? 16'h8000 : 16'($urandom() >> ($urandom_range(0, 3) * 4));
        vld[i] = ($urandom_range(0, 3) != 0);
      end
      runFrame("R4 R5 R6 R9 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule